// File: doc/BRIEF.md
# Per-Lane Timing Window Centering Engine

The engine trains eight byte lanes at once by sweeping their delay settings. Each round it asks an external pattern checker for one shared test and waits for the answer. The answer is an 8-bit vector with one fail flag per lane. Every lane that is still live then either takes one delay step, sent as a one-cycle strobe to the delay hardware, or retires. A step counter keeps track of how far each lane has moved.

Training has two phases that follow one after the other. In the first phase each lane looks for a passing result. In the second phase, which starts from the delay positions and counts where the first phase stopped, each lane looks for a failing result. A lane retires only after it has seen its target result and then taken ten further confirming steps. When both phases are complete, the engine takes nine off each lane's lower count and nine off its upper count, averages the two, and presents the centred counts in parallel. If the delay hardware reports a step error, the whole training stops with an error status.

Top module: `lane_window_centre`

## Requirements
- R1: After reset, done_o, error_o, test_req_o and every step_req_o bit are 0, and centre_o is all zero.
- R2: An accepted start pulse makes test_req_o high for exactly one cycle in the next cycle. Every later round raises test_req_o for one cycle, two cycles after the cycle in which the step strobes were shown.
- R3: fail_vec_i bit k belongs to lane k, and 1 means fail. In the cycle after test_ack_i, the step_req_o bit k of a live lane whose result is not its target pulses for one cycle, and that lane's count of the current phase rises by one. The target is pass in phase one and fail in phase two.
- R4: A live lane that shows its target result while its confirmation count is below 10 also steps and counts, and its confirmation count rises by one. The same lane showing its target result with a confirmation count of 10 retires and gets no strobe. A retired lane never steps again in that phase.
- R5: Phase one ends when no lane is live. Phase two then starts with every lane live, the confirmation counts cleared, each upper count set equal to its lower count, and the delay positions unchanged.
- R6: When phase two ends, done_o rises one cycle after the check cycle. At the same time, bits 8k+7..8k of centre_o show ((lower_k - 9) mod 256 + (upper_k - 9) mod 256) / 2, rounded down.
- R7: step_err_i is sampled in the cycle after the strobe cycle. If it is high, done_o and error_o both rise in the next cycle, and no further test request or step is issued.
- R8: done_o, error_o and centre_o hold until the next start. A start pulse while training is in progress is ignored. A start after an error clears error_o and trains afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only when the engine is idle or has finished |
| test_req_o | output | 1 | One-cycle request for a shared pattern test |
| test_ack_i | input | 1 | Test answer valid; fail_vec_i is sampled with it |
| fail_vec_i | input | 8 | Per-lane fail flags, 1 = fail |
| step_req_o | output | 8 | Per-lane one-cycle delay step strobes |
| step_err_i | input | 1 | Step error from the delay hardware, sampled in the cycle after the strobes |
| done_o | output | 1 | Training finished, held until the next start |
| error_o | output | 1 | Training aborted, held until the next start |
| centre_o | output | 64 | Eight centred step counts, lane k in bits 8k+7..8k |

## Verification
Each round runs on a fixed schedule. The strobes appear in the cycle after the acknowledge. The step error is looked at one cycle later. The next request, or done and error together with the centred counts, follows one cycle after that. The bench walks this schedule at falling edges. In each cycle it compares the strobe vector, the request line and the status outputs with a behavioural model of per-lane positions and pass windows. The answer latency varies from round to round. Stray start pulses and an unreachable window are used to exercise the ignore and abort paths.

// File: rtl/lwc_pkg.sv
// Shared types for the lane window centering engine.
package lwc_pkg;
    // Sequencer states of the sweep controller.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_STEP,
        ST_CHK,
        ST_FIN,
        ST_FAIL
    } lwc_state_e;
endpackage

// File: rtl/lwc_lane.sv
// One lane tracker: holds the lower and upper step counts, the confirmation
// count and the live flag. It decides on each evaluated round whether the
// lane steps or retires, and it forms the centred count from its two limits.
// Assumes eval_i, init_i and swap_i are single-cycle and mutually exclusive.
module lwc_lane #(
    parameter int CW         = 8,
    parameter int CONS_LIMIT = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic          swap_i,
    input  logic          eval_i,
    input  logic          phase_i,
    input  logic          fail_i,
    output logic          step_o,
    output logic          active_o,
    output logic [CW-1:0] centre_o
);
    localparam int KW   = $clog2(CONS_LIMIT + 1);
    localparam int CORR = CONS_LIMIT - 1;

    logic [CW-1:0] lower_q, upper_q;
    logic [KW-1:0] cons_q;
    logic          live_q, step_q;
    logic          target;
    logic [CW-1:0] lo_adj, up_adj;
    logic [CW:0]   sum_w;

    // Target result: pass in phase one, fail in phase two.
    assign target = phase_i ? fail_i : ~fail_i;

    // Per-round step or retire decision and counter upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lower_q <= '0;
            upper_q <= '0;
            cons_q  <= '0;
            live_q  <= 1'b0;
            step_q  <= 1'b0;
        end else if (init_i) begin
            lower_q <= '0;
            upper_q <= '0;
            cons_q  <= '0;
            live_q  <= 1'b1;
            step_q  <= 1'b0;
        end else if (swap_i) begin
            upper_q <= lower_q;
            cons_q  <= '0;
            live_q  <= 1'b1;
            step_q  <= 1'b0;
        end else if (eval_i && live_q) begin
            if (!target || (cons_q < KW'(CONS_LIMIT))) begin
                step_q <= 1'b1;
                if (phase_i) upper_q <= upper_q + 1'b1;
                else         lower_q <= lower_q + 1'b1;
                if (target)  cons_q  <= cons_q + 1'b1;
            end else begin
                step_q <= 1'b0;
                live_q <= 1'b0;
            end
        end else begin
            step_q <= 1'b0;
        end
    end

    // Corrected limits averaged with a floor.
    always_comb begin
        lo_adj   = lower_q - CW'(CORR);
        up_adj   = upper_q - CW'(CORR);
        sum_w    = {1'b0, lo_adj} + {1'b0, up_adj};
        centre_o = CW'(sum_w >> 1);
    end

    assign step_o   = step_q;
    assign active_o = live_q;
endmodule

// File: rtl/lwc_ctrl.sv
// Sweep sequencer: issues one test request per round, waits for the answer,
// lets the strobes go out, checks the step error, then moves on to the next
// round, the second phase, completion or abort. Assumes the test answer
// arrives some time after the request, with no limit on how long.
module lwc_ctrl
    import lwc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic test_ack_i,
    input  logic step_err_i,
    input  logic lanes_idle_i,
    output logic test_req_o,
    output logic init_o,
    output logic eval_o,
    output logic swap_o,
    output logic finish_o,
    output logic phase_o,
    output logic done_o,
    output logic error_o
);
    lwc_state_e st_q, st_d;
    logic       phase_q;
    logic       can_start;
    logic       chk_ok;

    assign can_start = (st_q == ST_IDLE) || (st_q == ST_FIN) || (st_q == ST_FAIL);
    assign init_o    = start_i && can_start;
    assign eval_o    = (st_q == ST_WAIT) && test_ack_i;
    assign chk_ok    = (st_q == ST_CHK) && !step_err_i && lanes_idle_i;
    assign swap_o    = chk_ok && !phase_q;
    assign finish_o  = chk_ok && phase_q;
    assign test_req_o = (st_q == ST_REQ);
    assign done_o    = (st_q == ST_FIN) || (st_q == ST_FAIL);
    assign error_o   = (st_q == ST_FAIL);
    assign phase_o   = phase_q;

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE, ST_FIN, ST_FAIL: if (init_o) st_d = ST_REQ;
            ST_REQ:  st_d = ST_WAIT;
            ST_WAIT: if (test_ack_i) st_d = ST_STEP;
            ST_STEP: st_d = ST_CHK;
            ST_CHK: begin
                if (step_err_i)                   st_d = ST_FAIL;
                else if (lanes_idle_i && phase_q) st_d = ST_FIN;
                else                              st_d = ST_REQ;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State and phase registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            phase_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (init_o)      phase_q <= 1'b0;
            else if (swap_o) phase_q <= 1'b1;
        end
    end
endmodule

// File: rtl/lane_window_centre.sv
// Top of the lane window centering engine: one sequencer, one tracker per
// lane, and a register that captures the centred counts when training
// completes. Assumes the delay hardware takes one step per strobe bit.
module lane_window_centre #(
    parameter int LANES      = 8,
    parameter int CW         = 8,
    parameter int CONS_LIMIT = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    output logic                test_req_o,
    input  logic                test_ack_i,
    input  logic [LANES-1:0]    fail_vec_i,
    output logic [LANES-1:0]    step_req_o,
    input  logic                step_err_i,
    output logic                done_o,
    output logic                error_o,
    output logic [LANES*CW-1:0] centre_o
);
    logic                init_w, eval_w, swap_w, finish_w, phase_w;
    logic [LANES-1:0]    live_w;
    logic [LANES*CW-1:0] centre_w;
    logic [LANES*CW-1:0] centre_q;

    lwc_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .test_ack_i   (test_ack_i),
        .step_err_i   (step_err_i),
        .lanes_idle_i (~|live_w),
        .test_req_o   (test_req_o),
        .init_o       (init_w),
        .eval_o       (eval_w),
        .swap_o       (swap_w),
        .finish_o     (finish_w),
        .phase_o      (phase_w),
        .done_o       (done_o),
        .error_o      (error_o)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lwc_lane #(
            .CW         (CW),
            .CONS_LIMIT (CONS_LIMIT)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .init_i   (init_w),
            .swap_i   (swap_w),
            .eval_i   (eval_w),
            .phase_i  (phase_w),
            .fail_i   (fail_vec_i[k]),
            .step_o   (step_req_o[k]),
            .active_o (live_w[k]),
            .centre_o (centre_w[k*CW +: CW])
        );
    end

    // Capture the centred counts on completion; clear them on start.
    always_ff @(posedge clk) begin
        if (!rst_n)        centre_q <= '0;
        else if (init_w)   centre_q <= '0;
        else if (finish_w) centre_q <= centre_w;
    end

    assign centre_o = centre_q;
endmodule

// File: rtl/lwc_checker.sv
// Port-level protocol properties of the centering engine, bound to its top.
module lwc_checker #(
    parameter int LANES = 8,
    parameter int CW    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                test_req_o,
    input logic                test_ack_i,
    input logic [LANES-1:0]    step_req_o,
    input logic                done_o,
    input logic                error_o,
    input logic [LANES*CW-1:0] centre_o
);
    // R2: a request lasts exactly one cycle
    a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        test_req_o |=> !test_req_o);

    // R3: strobes only follow a test answer
    a_r3_step_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (|step_req_o) |-> $past(test_ack_i));

    // R7: an aborted run reports done as well
    a_r7_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> done_o);

    // R7: nothing is issued once training has ended
    a_r7_quiet_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!test_req_o && (step_req_o == '0)));

    // R8: status holds until a new start
    a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R8: the error flag holds until a new start
    a_r8_error_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (error_o && !start_i) |=> error_o);

    // R6: results stay put while finished
    a_r6_centre_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> $stable(centre_o));
endmodule

bind lane_window_centre lwc_checker #(.LANES(LANES), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .test_req_o (test_req_o),
    .test_ack_i (test_ack_i),
    .step_req_o (step_req_o),
    .done_o     (done_o),
    .error_o    (error_o),
    .centre_o   (centre_o)
);

// File: tb/sim_lane_window_centre.sv
`timescale 1ns/1ps
module sim_lane_window_centre;
    localparam int LANES  = 8;
    localparam int CW     = 8;
    localparam int MAXPOS = 80;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start_i = 1'b0;
    logic                test_ack_i = 1'b0;
    logic [LANES-1:0]    fail_vec_i = '0;
    logic                step_err_i = 1'b0;
    logic                test_req_o, done_o, error_o;
    logic [LANES-1:0]    step_req_o;
    logic [LANES*CW-1:0] centre_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    int  lo[LANES], hi[LANES];
    int  pos[LANES], mlow[LANES], mup[LANES], mcons[LANES];
    bit  mact[LANES];
    bit  mphase;

    always #2.5 clk = ~clk;

    lane_window_centre u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .test_req_o (test_req_o),
        .test_ack_i (test_ack_i),
        .fail_vec_i (fail_vec_i),
        .step_req_o (step_req_o),
        .step_err_i (step_err_i),
        .done_o     (done_o),
        .error_o    (error_o),
        .centre_o   (centre_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_windows(input int sel);
        int la[LANES] = '{0, 1, 2, 3, 4, 6, 8, 10};
        int ha[LANES] = '{14, 18, 25, 20, 30, 22, 28, 35};
        int lb[LANES] = '{5, 0, 7, 2, 9, 1, 4, 3};
        int hb[LANES] = '{25, 12, 40, 30, 22, 16, 19, 33};
        for (int k = 0; k < LANES; k++) begin
            lo[k] = (sel == 1) ? lb[k] : la[k];
            hi[k] = (sel == 1) ? hb[k] : ha[k];
        end
        if (sel == 2) begin
            lo[5] = 50;
            hi[5] = 52;
        end
    endtask

    function automatic logic [63:0] exp_centres();
        logic [63:0] v = '0;
        for (int k = 0; k < LANES; k++)
            v[k*8 +: 8] = 8'(((((mlow[k] - 9) & 255) + ((mup[k] - 9) & 255)) / 2));
        return v;
    endfunction

    // Runs one training with the current windows; returns 1 on abort.
    task automatic run_training(input int lat_mode, input bit poke_start, output bit aborted);
        int round = 0;
        bit err, any_live, stop;
        logic [LANES-1:0] fv, exp_step;
        aborted = 1'b0;
        stop = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            pos[k] = 0; mlow[k] = 0; mup[k] = 0; mcons[k] = 0; mact[k] = 1'b1;
        end
        mphase = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!stop && round < 3000) begin
            chk("R2 request after start or check", test_req_o, 1);
            chk("R8 done low while running", done_o, 0);
            @(negedge clk);
            begin
                int lat = 1 + ((round * lat_mode) % 3);
                if (poke_start && round == 3) lat = 2;
                for (int w = 1; w < lat; w++) begin
                    chk("R2 single request pulse", test_req_o, 0);
                    if (poke_start && round == 3) start_i = 1'b1;
                    @(negedge clk);
                    start_i = 1'b0;
                end
            end
            for (int k = 0; k < LANES; k++)
                fv[k] = (pos[k] < lo[k]) || (pos[k] > hi[k]);
            fail_vec_i = fv;
            test_ack_i = 1'b1;
            @(negedge clk);
            test_ack_i = 1'b0;
            fail_vec_i = '0;
            exp_step = '0;
            for (int k = 0; k < LANES; k++) begin
                bit tgt = mphase ? fv[k] : !fv[k];
                if (mact[k]) begin
                    if (!tgt || mcons[k] < 10) begin
                        exp_step[k] = 1'b1;
                        if (mphase) mup[k]++; else mlow[k]++;
                        if (tgt) mcons[k]++;
                    end else begin
                        mact[k] = 1'b0;
                    end
                end
            end
            chk("R3 R4 step strobes after answer", step_req_o, exp_step);
            err = 1'b0;
            for (int k = 0; k < LANES; k++)
                if (exp_step[k]) begin
                    pos[k]++;
                    if (pos[k] > MAXPOS) err = 1'b1;
                end
            step_err_i = err;
            @(negedge clk);
            chk("R3 strobe is one cycle", step_req_o, 0);
            chk("R2 no request in check cycle", test_req_o, 0);
            @(negedge clk);
            step_err_i = 1'b0;
            any_live = 1'b0;
            for (int k = 0; k < LANES; k++) any_live |= mact[k];
            if (err) begin
                chk("R7 done on step error", done_o, 1);
                chk("R7 error on step error", error_o, 1);
                aborted = 1'b1;
                stop = 1'b1;
            end else if (!any_live && !mphase) begin
                mphase = 1'b1;
                for (int k = 0; k < LANES; k++) begin
                    mup[k] = mlow[k]; mcons[k] = 0; mact[k] = 1'b1;
                end
                chk("R5 second phase begins", test_req_o, 1);
            end else if (!any_live) begin
                chk("R6 done after second phase", done_o, 1);
                chk("R6 no error on success", error_o, 0);
                chk("R6 centred counts", centre_o, exp_centres());
                stop = 1'b1;
            end
            round++;
        end
        if (!stop) chk("R2 training ends", 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit ab;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", done_o, 0);
        chk("R1 error after reset", error_o, 0);
        chk("R1 request after reset", test_req_o, 0);
        chk("R1 strobes after reset", step_req_o, 0);
        chk("R1 centres after reset", centre_o, 0);

        set_windows(0);
        run_training(1, 1'b0, ab);
        chk("R6 run A not aborted", ab, 0);
        chk("R6 lane 3 hand value", centre_o[3*8 +: 8], 13);
        repeat (4) @(negedge clk);
        chk("R8 done held", done_o, 1);
        chk("R8 centres held", centre_o, exp_centres());

        set_windows(1);
        run_training(2, 1'b1, ab);
        chk("R8 start while busy ignored", ab, 0);

        set_windows(2);
        run_training(1, 1'b0, ab);
        chk("R7 run aborts", ab, 1);
        repeat (5) begin
            @(negedge clk);
            chk("R7 no request after abort", test_req_o, 0);
            chk("R8 error held", error_o, 1);
        end

        set_windows(0);
        run_training(0, 1'b0, ab);
        chk("R8 restart after error", ab, 0);
        chk("R8 error cleared by start", error_o, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule